// File: doc/BRIEF.md
# Two-Word-Instruction Stored-Program Processor

A small processor with four 16-bit general registers and a unified 256-word memory that holds both code and data. Each instruction occupies one or two words. The short forms (no-op, add, subtract, halt) are a single word. The memory read and the two branches carry a second word. For the read, that second word is the address of the data. For a branch, it names a cell whose contents are the new program counter, so every branch target is fetched indirectly.

The memory sits inside the block as a synchronous-read array. A testbench fills it while reset is held, then releases reset, and the processor starts fetching at address 0. A multi-cycle controller steps each instruction through fetch, decode, an optional operand fetch and indirect fetch, then execute. The program counter, the register file contents, the zero flag and a halted indication are brought out as registered ports so that progress can be followed cycle by cycle.

Top module: `tw_cpu_top`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is 0 at a rising edge, the next cycle shows `pc_o`=0, all registers 0, `zero_o`=0 and `halted_o`=0. This state holds for as long as reset stays low. The first rising edge with `rst_n`=1 starts a fetch from address 0.
- R2: An instruction word decodes as follows: opcode in bits 7:4, source register in bits 3:2 and destination register in bits 1:0. Bits 15:8 are ignored. The opcodes are 0x0 no-op, 0x1 add, 0x2 subtract, 0x5 read, 0x7 branch, 0x8 branch-if-zero and 0xF halt. Any other opcode behaves as a one-word no-op.
- R3: Add writes (src + dest) mod 2^16 into dest. Subtract writes (dest − src) mod 2^16 into dest. In both cases `zero_o` becomes 1 exactly when the written result is 0.
- R4: Read loads mem[operand[7:0]] into dest, where the operand is the word that follows the instruction.
- R5: Branch loads bits 7:0 of mem[operand[7:0]] into the program counter.
- R6: Branch-if-zero jumps like R5 when `zero_o` is 1. Otherwise it continues at the instruction address + 2.
- R7: Halt sets `halted_o` and leaves `pc_o` at the halt address + 1. After that, `pc_o`, the registers and `zero_o` do not change until reset.
- R8: Cycle timing, counted from the first cycle of a fetch: `pc_o` increments after the second cycle. A one-word instruction retires its results after the third cycle and the next fetch begins in the fourth. A two-word instruction increments `pc_o` again after the third cycle, applies its results after the fifth cycle, and the next fetch begins in the sixth.
- R9: Only add and subtract change `zero_o`. Read, the branches, no-op and unused opcodes leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_o | output | 8 | Program counter |
| gpr_o | output | 64 | Register file, register i in bits 16*i+15 : 16*i |
| zero_o | output | 1 | Zero flag from the last add or subtract |
| halted_o | output | 1 | High once a halt has been decoded |

## Verification
Suppose the controller holds a wrong state, for example it treats a two-word opcode as one word, or it takes the wrong pointer step. Within one or two cycles `pc_o` then leaves the increments and jumps of R8. The following fetch decodes a data word as code, so a wrong register value or a wrong halt soon follows. A bad indirect address, or a zero flag that a read touched, first shows in `pc_o` at the end of the branch that uses it, five cycles after that branch began. The bench compares every port on every cycle against its own instruction-level model, so the first divergent cycle is reported.

// File: rtl/tw_cpu_pkg.sv
package tw_cpu_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_READ = 4'h5,
    OP_BR   = 4'h7,
    OP_BRZ  = 4'h8,
    OP_HALT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_OPND,
    ST_INDIR,
    ST_EXEC,
    ST_HALT
  } state_e;

  // opcodes that carry a second (operand) word
  function automatic logic needs_operand(input logic [3:0] op);
    return (op == OP_READ) || (op == OP_BR) || (op == OP_BRZ);
  endfunction

endpackage

// File: rtl/tw_cpu_mem.sv
module tw_cpu_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  // unified code/data store, preloaded from outside; read-only to the core
  logic [DATA_W-1:0] mem_q [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] = '0;
  end

  // synchronous read port, no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    rdata_o <= mem_q[addr_i];
  end

endmodule

// File: rtl/tw_cpu_regfile.sv
module tw_cpu_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [$clog2(NREG)-1:0]  waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [$clog2(NREG)-1:0]  raddr_a_i,
  input  logic [$clog2(NREG)-1:0]  raddr_b_i,
  output logic [DATA_W-1:0]        rdata_a_o,
  output logic [DATA_W-1:0]        rdata_b_o,
  output logic [NREG*DATA_W-1:0]   flat_o
);
  localparam int RIDX_W = $clog2(NREG);

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                regs_q[i] <= '0;
      else if (we_i && (waddr_i == RIDX_W'(i)))  regs_q[i] <= wdata_i;
    end
    assign flat_o[i*DATA_W +: DATA_W] = regs_q[i];
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

endmodule

// File: rtl/tw_cpu_alu.sv
module tw_cpu_alu
  import tw_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              flag_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  always_comb begin
    if (op_i == OP_SUB) result_o = dst_i - src_i;
    else                result_o = dst_i + src_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         zero_o <= 1'b0;
    else if (flag_en_i) zero_o <= (result_o == '0);
  end

endmodule

// File: rtl/tw_cpu_ctrl.sv
module tw_cpu_ctrl
  import tw_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int RIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              zero_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [3:0]        op_o,
  output logic [RIDX_W-1:0] src_o,
  output logic [RIDX_W-1:0] dst_o,
  output logic              rf_we_o,
  output logic              rf_from_mem_o,
  output logic              flag_en_o,
  output state_e            state_o,
  output logic              halted_o
);
  localparam int SRC_LSB = RIDX_W;
  localparam int OP_LSB  = 2 * RIDX_W;
  localparam int IR_W    = OP_LSB + 4;

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [IR_W-1:0]   ir_q;
  logic              halted_q;
  logic [3:0]        new_op;
  logic              in_exec;
  logic              alu_op;
  logic              take_jump;
  logic              unused_rdata;

  assign new_op       = mem_rdata_i[OP_LSB +: 4];
  assign op_o         = ir_q[OP_LSB +: 4];
  assign src_o        = ir_q[SRC_LSB +: RIDX_W];
  assign dst_o        = ir_q[RIDX_W-1:0];
  assign unused_rdata = ^mem_rdata_i;

  assign in_exec       = (state_q == ST_EXEC);
  assign alu_op        = (op_o == OP_ADD) || (op_o == OP_SUB);
  assign rf_we_o       = in_exec && (alu_op || (op_o == OP_READ));
  assign rf_from_mem_o = (op_o == OP_READ);
  assign flag_en_o     = in_exec && alu_op;
  assign take_jump     = (op_o == OP_BR) || ((op_o == OP_BRZ) && zero_i);

  // indirect fetch uses the operand word just read as the address
  always_comb begin
    if (state_q == ST_INDIR) mem_addr_o = mem_rdata_i[ADDR_W-1:0];
    else                     mem_addr_o = pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      ir_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:   state_q <= ST_FETCH;
        ST_FETCH:  state_q <= ST_DECODE;
        ST_DECODE: begin
          ir_q <= mem_rdata_i[IR_W-1:0];
          pc_q <= pc_q + ADDR_W'(1);
          if (new_op == OP_HALT) begin
            state_q  <= ST_HALT;
            halted_q <= 1'b1;
          end else if (needs_operand(new_op)) begin
            state_q <= ST_OPND;
          end else begin
            state_q <= ST_EXEC;
          end
        end
        ST_OPND: begin
          pc_q    <= pc_q + ADDR_W'(1);
          state_q <= ST_INDIR;
        end
        ST_INDIR:  state_q <= ST_EXEC;
        ST_EXEC: begin
          if (take_jump) pc_q <= mem_rdata_i[ADDR_W-1:0];
          state_q <= ST_FETCH;
        end
        ST_HALT:   state_q <= ST_HALT;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign state_o  = state_q;
  assign halted_o = halted_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q); // R7
  AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> $stable(pc_q)); // R7
  AST_DECODE_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R8

endmodule

// File: rtl/tw_cpu_top.sv
module tw_cpu_top
  import tw_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NREG   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [ADDR_W-1:0]      pc_o,
  output logic [NREG*DATA_W-1:0] gpr_o,
  output logic                   zero_o,
  output logic                   halted_o
);
  localparam int RIDX_W = $clog2(NREG);

  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic [3:0]        op;
  logic [RIDX_W-1:0] src_idx;
  logic [RIDX_W-1:0] dst_idx;
  logic              rf_we;
  logic              rf_from_mem;
  logic              flag_en;
  state_e            state;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] dst_val;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] wdata;

  tw_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .addr_i  (mem_addr),
    .rdata_o (mem_rdata)
  );

  tw_cpu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_rdata_i   (mem_rdata),
    .zero_i        (zero_o),
    .mem_addr_o    (mem_addr),
    .pc_o          (pc_o),
    .op_o          (op),
    .src_o         (src_idx),
    .dst_o         (dst_idx),
    .rf_we_o       (rf_we),
    .rf_from_mem_o (rf_from_mem),
    .flag_en_o     (flag_en),
    .state_o       (state),
    .halted_o      (halted_o)
  );

  assign wdata = rf_from_mem ? mem_rdata : alu_res;

  tw_cpu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (rf_we),
    .waddr_i   (dst_idx),
    .wdata_i   (wdata),
    .raddr_a_i (src_idx),
    .raddr_b_i (dst_idx),
    .rdata_a_o (src_val),
    .rdata_b_o (dst_val),
    .flat_o    (gpr_o)
  );

  tw_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op),
    .src_i     (src_val),
    .dst_i     (dst_val),
    .flag_en_i (flag_en),
    .result_o  (alu_res),
    .zero_o    (zero_o)
  );

  AST_ZERO_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_EXEC) |=> $stable(zero_o)); // R9
  AST_REGS_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_EXEC) |=> $stable(gpr_o)); // R3
  AST_HALT_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> ($stable(gpr_o) && $stable(zero_o))); // R7

endmodule

// File: tb/tw_cpu_top_tb_top.sv
`timescale 1ns/1ps
module tw_cpu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pc_o;
  logic [63:0] gpr_o;
  logic        zero_o;
  logic        halted_o;

  always #2.5 clk = ~clk;

  tw_cpu_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_o     (pc_o),
    .gpr_o    (gpr_o),
    .zero_o   (zero_o),
    .halted_o (halted_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench program image and instruction-level model
  logic [15:0] img [256];
  logic [7:0]  m_pc;
  logic [15:0] m_r [4];
  logic        m_z, m_halt, m_started;
  int          m_k;
  logic [15:0] m_ir, m_opw;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_flat();
    return {m_r[3], m_r[2], m_r[1], m_r[0]};
  endfunction

  task automatic model_step(input logic r);
    logic [3:0]  op;
    logic [1:0]  s, d;
    logic [15:0] v;
    if (!r) begin
      m_pc = 0; m_z = 0; m_halt = 0; m_started = 0; m_k = 0;
      for (int i = 0; i < 4; i++) m_r[i] = 0;
      return;
    end
    if (!m_started) begin m_started = 1; m_k = 0; return; end
    if (m_halt) return;
    op = m_ir[7:4]; s = m_ir[3:2]; d = m_ir[1:0];
    case (m_k)
      0: m_k = 1;
      1: begin
        m_ir = img[m_pc]; m_pc = m_pc + 1;
        if (m_ir[7:4] == 4'hF) m_halt = 1;
        else if (m_ir[7:4] == 4'h5 || m_ir[7:4] == 4'h7 || m_ir[7:4] == 4'h8) m_k = 2;
        else m_k = 5;
      end
      5: begin
        if (op == 4'h1) begin m_r[d] = m_r[s] + m_r[d]; m_z = (m_r[d] == 0); end
        if (op == 4'h2) begin m_r[d] = m_r[d] - m_r[s]; m_z = (m_r[d] == 0); end
        m_k = 0;
      end
      2: begin m_opw = img[m_pc]; m_pc = m_pc + 1; m_k = 3; end
      3: m_k = 4;
      default: begin
        v = img[m_opw[7:0]];
        if (op == 4'h5) m_r[d] = v;
        if (op == 4'h7 || (op == 4'h8 && m_z)) m_pc = v[7:0];
        m_k = 0;
      end
    endcase
  endtask

  task automatic compare_all();
    chk("R8", "pc per cycle", {56'd0, pc_o}, {56'd0, m_pc});
    chk("R3", "registers per cycle", gpr_o, m_flat());
    chk("R9", "zero flag per cycle", {63'd0, zero_o}, {63'd0, m_z});
    chk("R7", "halted per cycle", {63'd0, halted_o}, {63'd0, m_halt});
  endtask

  task automatic tick(input logic r);
    rst_n = r;
    @(posedge clk);
    model_step(r);
    @(negedge clk);
    compare_all();
  endtask

  task automatic load_image();
    for (int i = 0; i < 256; i++) dut_i.u_mem.mem_q[i] = img[i];
  endtask

  task automatic clear_image();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
  endtask

  // countdown: R1 counts 5 down by R2=1, R0 accumulates R3=3 each pass
  task automatic prog_countdown();
    clear_image();
    img[0]  = 16'h0000;                  // no-op
    img[1]  = 16'h0051; img[2]  = 16'h0040; // read R1
    img[3]  = 16'h0052; img[4]  = 16'h0041; // read R2
    img[5]  = 16'h0053; img[6]  = 16'h0042; // read R3
    img[7]  = 16'h0029;                  // R1 = R1 - R2
    img[8]  = 16'h0080; img[9]  = 16'h0043; // branch-if-zero via cell 0x43
    img[10] = 16'h001C;                  // R0 = R3 + R0
    img[11] = 16'h0070; img[12] = 16'h0044; // branch via cell 0x44
    img[14] = 16'h00F0;                  // halt
    img[8'h40] = 16'd5; img[8'h41] = 16'd1; img[8'h42] = 16'd3;
    img[8'h43] = 16'd14; img[8'h44] = 16'd7;
  endtask

  // wrap, read keeps flag, taken branch-if-zero, junk opcode, not-taken branch-if-zero
  task automatic prog_corners();
    clear_image();
    img[0] = 16'h0050; img[1] = 16'h0050;   // read R0 = 0xFFFF
    img[2] = 16'h0051; img[3] = 16'h0051;   // read R1 = 1
    img[4] = 16'h0011;                      // R1 = R0 + R1 -> 0, zero set
    img[5] = 16'h0052; img[6] = 16'h0052;   // read R2 = 7, zero kept
    img[7] = 16'h0080; img[8] = 16'h0053;   // taken via cell 0x53 -> 0x20
    img[9] = 16'h00F0;                      // skipped halt
    img[8'h20] = 16'hAB3F;                  // unused opcode 3, junk upper byte
    img[8'h21] = 16'h0028;                  // R0 = R0 - R2 -> 0xFFF8
    img[8'h22] = 16'h0080; img[8'h23] = 16'h0054; // not taken
    img[8'h24] = 16'h00F0;                  // halt
    img[8'h50] = 16'hFFFF; img[8'h51] = 16'h0001; img[8'h52] = 16'h0007;
    img[8'h53] = 16'h0020; img[8'h54] = 16'h0030;
  endtask

  task automatic run_to_halt(input int limit);
    int c;
    c = 0;
    while (!(m_halt && halted_o) && c < limit) begin tick(1'b1); c++; end
    chk("R7", "program reached halt in time", {63'd0, halted_o}, 64'd1);
  endtask

  task automatic check_countdown_end();
    chk("R3", "R0 accumulated", {48'd0, gpr_o[15:0]}, 64'd12);
    chk("R3", "R1 counted to zero", {48'd0, gpr_o[31:16]}, 64'd0);
    chk("R4", "R2 read value", {48'd0, gpr_o[47:32]}, 64'd1);
    chk("R4", "R3 read value", {48'd0, gpr_o[63:48]}, 64'd3);
    chk("R6", "taken exit, pc after halt", {56'd0, pc_o}, 64'd15);
    chk("R3", "zero after final subtract", {63'd0, zero_o}, 64'd1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    prog_countdown();
    #1 load_image();
    // R1 reset state
    for (int i = 0; i < 3; i++) tick(1'b0);
    chk("R1", "pc in reset", {56'd0, pc_o}, 64'd0);
    chk("R1", "regs in reset", gpr_o, 64'd0);
    chk("R1", "halted in reset", {63'd0, halted_o}, 64'd0);
    tick(1'b1); tick(1'b1); tick(1'b1);
    chk("R8", "pc after fetch+decode of first word", {56'd0, pc_o}, 64'd1);
    run_to_halt(2000);
    check_countdown_end();
    for (int i = 0; i < 12; i++) tick(1'b1);
    chk("R7", "pc frozen after halt", {56'd0, pc_o}, 64'd15);

    // corner program
    tick(1'b0); tick(1'b0);
    prog_corners();
    load_image();
    tick(1'b0);
    run_to_halt(2000);
    chk("R3", "subtract wrapped", {48'd0, gpr_o[15:0]}, 64'h0000_0000_0000_FFF8);
    chk("R3", "add wrapped to 0", {48'd0, gpr_o[31:16]}, 64'd0);
    chk("R4", "R2 read", {48'd0, gpr_o[47:32]}, 64'd7);
    chk("R2", "unused opcode left R3", {48'd0, gpr_o[63:48]}, 64'd0);
    chk("R5", "indirect jump then not-taken skip reached 0x24 halt", {56'd0, pc_o}, 64'h25);
    chk("R9", "flag from last subtract", {63'd0, zero_o}, 64'd0);

    // reset in the middle of a run
    tick(1'b0); tick(1'b0);
    prog_countdown();
    load_image();
    tick(1'b0);
    for (int i = 0; i < 40; i++) tick(1'b1);
    for (int i = 0; i < 4; i++) begin
      tick(1'b0);
      chk("R1", "pc held while reset low", {56'd0, pc_o}, 64'd0);
    end
    run_to_halt(2000);
    check_countdown_end();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule